// File: doc/BRIEF.md
# GPIO Pin Interrupt Sense and Pending Unit

This block watches up to 32 general-purpose input pins and turns activity on each one into a pending interrupt bit. Every pin has its own 4-bit sense field. The low three bits of the field pick the kind of activity to catch: a rising edge, a falling edge, a high level, a low level, or either edge. The top bit of the field picks the sampling path. The pin can be taken straight into the detector, or it can first pass through a two-stage synchronizer.

Events are latched only for pins whose detection-enable bit is set. Software clears pending bits by writing ones. A separate enable vector decides which pending bits reach the masked status view and the two interrupt request lines. The enable vector is changed through a write-one-to-set register and a write-one-to-clear register. The lower half of the pins feeds one request line and the upper half feeds the other.

All registers sit on a simple 32-bit strobe bus. A write takes effect on the clock edge where the select and write strobes are high. Reads are combinational from the address.

Top module: `gis_top`

## Requirements
- R1: After reset, every register reads 0 and both request lines are low: detection is disabled, all pins are masked, all sense fields are 0 and nothing is pending.
- R2: The sense field of pin n is 4 bits wide and is read and written at byte offset 0x20 + 4*(n/8), in bits 4*(n%8)+3 down to 4*(n%8). A write stores the whole word, and a read returns it unchanged.
- R3: Bits 2:0 of a sense field select the kind of activity. The value 0 catches a rising edge, 1 a falling edge, 2 a high level, 3 a low level and 4 either edge. The values 5, 6 and 7 never latch anything.
- R4: When bit 3 of the sense field is 1, the pin is sampled directly: a change made between clock edges is pending after the next edge. When bit 3 is 0, the pin passes through a two-stage synchronizer and the change is pending after the third edge.
- R5: The detection-enable vector at offset 0x00 is readable and writable. A pin whose bit is 0 never gets a new pending bit.
- R6: Writing to offset 0x04 sets the enable bits where the written data is 1. Writing to offset 0x08 clears the enable bits where the written data is 1. Zero bits leave the vector unchanged, and offset 0x04 reads the vector back.
- R7: Offset 0x0C reads the raw pending vector. Offset 0x10 reads the pending vector ANDed with the enable vector. A pending bit stays set until it is cleared.
- R8: Writing to offset 0x14 clears each pending bit where the written data is 1. Zero bits have no effect.
- R9: In a level mode, if a clear meets a level that is still active, the bit reads 0 right after the clear and is set again one clock edge later.
- R10: If an edge is detected on the same clock edge as a clear of that pin's bit, the edge wins and the bit is set.
- R11: `irq_lo` is high while any masked status bit of pins 0 to 15 is set. `irq_hi` is high while any masked status bit of pins 16 to 31 is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 32 | Pin levels being watched |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write qualifier for bus_sel |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_lo | output | 1 | Request line for pins 0 to 15 |
| irq_hi | output | 1 | Request line for pins 16 to 31 |

## Verification
The bench runs every pin through all five detection kinds, once on the direct path and once on the synchronized path. For each run it checks the exact edge on which the pending bit appears. A design that swapped the two paths, or mis-mapped a sense field to the wrong pin, would latch one edge early or late, or would react to the wrong polarity. A level mode that let a clear win outright, or ignored the clear altogether, would miss the one-cycle zero and the re-set that follows. A clear issued on the same edge as a fresh edge would lose the event if the priority were reversed. Partial writes to the enable and clear registers show whether zero bits really leave the other pins alone. The request line of the other half must stay low throughout; a wrong half split would raise it.

// File: rtl/gis_pkg.sv
package gis_pkg;

  // Register byte offsets
  localparam int OFF_DETEN  = 'h00;
  localparam int OFF_UNMASK = 'h04;
  localparam int OFF_MASK   = 'h08;
  localparam int OFF_RAW    = 'h0C;
  localparam int OFF_STATUS = 'h10;
  localparam int OFF_CLEAR  = 'h14;
  localparam int OFF_SENSE  = 'h20;

  localparam int FIELD_W = 4;

  typedef enum logic [2:0] {
    SNS_RISE = 3'd0,
    SNS_FALL = 3'd1,
    SNS_HIGH = 3'd2,
    SNS_LOW  = 3'd3,
    SNS_BOTH = 3'd4
  } sense_kind_e;

  // Returns {level_event, edge_event} for one pin
  function automatic logic [1:0] sense_eval(input logic [2:0] kind,
                                            input logic cur, input logic prv);
    logic lvl, edg;
    lvl = 1'b0;
    edg = 1'b0;
    case (kind)
      SNS_RISE: edg = cur & ~prv;
      SNS_FALL: edg = ~cur & prv;
      SNS_HIGH: lvl = cur;
      SNS_LOW:  lvl = ~cur;
      SNS_BOTH: edg = cur ^ prv;
      default: begin
        lvl = 1'b0;
        edg = 1'b0;
      end
    endcase
    return {lvl, edg};
  endfunction

  // Byte offset of the sense word that holds a pin
  function automatic int sense_offset(input int pin, input int fields_per_word);
    return OFF_SENSE + 4 * (pin / fields_per_word);
  endfunction

  // Lowest bit of a pin's field inside its sense word
  function automatic int sense_lsb(input int pin, input int fields_per_word);
    return FIELD_W * (pin % fields_per_word);
  endfunction

endpackage

// File: rtl/gis_regs.sv
module gis_regs
  import gis_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  localparam int FPW   = DATA_W / FIELD_W,
  localparam int NSREG = (NPINS + FPW - 1) / FPW
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_sel,
  input  logic                    bus_we,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [DATA_W-1:0]       bus_wdata,
  input  logic [NPINS-1:0]        pend_q,
  input  logic [NPINS-1:0]        status_w,
  output logic [NPINS-1:0]        det_en_q,
  output logic [NPINS-1:0]        unmask_q,
  output logic [NSREG*DATA_W-1:0] sense_flat,
  output logic [NPINS-1:0]        clr_vec,
  output logic                    wr_unmask,
  output logic                    wr_mask,
  output logic [DATA_W-1:0]       bus_rdata
);

  logic              wr;
  logic              wr_deten;
  logic              wr_clear;
  logic [NPINS-1:0]  wdata_pins;
  logic [DATA_W-1:0] sense_words [NSREG];

  assign wr         = bus_sel & bus_we;
  assign wr_deten   = wr && (bus_addr == ADDR_W'(OFF_DETEN));
  assign wr_unmask  = wr && (bus_addr == ADDR_W'(OFF_UNMASK));
  assign wr_mask    = wr && (bus_addr == ADDR_W'(OFF_MASK));
  assign wr_clear   = wr && (bus_addr == ADDR_W'(OFF_CLEAR));
  assign wdata_pins = bus_wdata[NPINS-1:0];
  assign clr_vec    = wr_clear ? wdata_pins : '0;

  // Detection enable: plain read/write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      det_en_q <= '0;
    end else if (wr_deten) begin
      det_en_q <= wdata_pins;
    end
  end

  // Interrupt enable: set by one register, cleared by another
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unmask_q <= '0;
    end else if (wr_unmask) begin
      unmask_q <= unmask_q | wdata_pins;
    end else if (wr_mask) begin
      unmask_q <= unmask_q & ~wdata_pins;
    end
  end

  // Sense words
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NSREG; r++) sense_words[r] <= '0;
    end else begin
      for (int r = 0; r < NSREG; r++) begin
        if (wr && (bus_addr == ADDR_W'(OFF_SENSE + 4 * r))) begin
          sense_words[r] <= bus_wdata;
        end
      end
    end
  end

  genvar gr;
  generate
    for (gr = 0; gr < NSREG; gr++) begin : g_flat
      assign sense_flat[gr*DATA_W +: DATA_W] = sense_words[gr];
    end
  endgenerate

  // Combinational read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFF_DETEN))  bus_rdata = DATA_W'(det_en_q);
    if (bus_addr == ADDR_W'(OFF_UNMASK)) bus_rdata = DATA_W'(unmask_q);
    if (bus_addr == ADDR_W'(OFF_RAW))    bus_rdata = DATA_W'(pend_q);
    if (bus_addr == ADDR_W'(OFF_STATUS)) bus_rdata = DATA_W'(status_w);
    for (int r = 0; r < NSREG; r++) begin
      if (bus_addr == ADDR_W'(OFF_SENSE + 4 * r)) bus_rdata = sense_words[r];
    end
  end

endmodule

// File: rtl/gis_detect.sv
module gis_detect
  import gis_pkg::*;
#(
  parameter int NPINS       = 32,
  parameter int SENSE_W     = 128,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NPINS-1:0]   pin_in,
  input  logic [SENSE_W-1:0] sense_flat,
  output logic [NPINS-1:0]   edge_evt,
  output logic [NPINS-1:0]   level_evt
);

  genvar gi;
  generate
    for (gi = 0; gi < NPINS; gi++) begin : g_pin
      logic [SYNC_STAGES-1:0] chain_q;
      logic                   prev_q;
      logic                   smp;
      logic [FIELD_W-1:0]     code;
      logic [1:0]             hit;

      assign code = sense_flat[gi*FIELD_W +: FIELD_W];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain_q <= '0;
        end else begin
          chain_q <= {chain_q[SYNC_STAGES-2:0], pin_in[gi]};
        end
      end

      // Bit 3 chooses the direct path over the synchronizer
      assign smp = code[FIELD_W-1] ? pin_in[gi] : chain_q[SYNC_STAGES-1];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          prev_q <= 1'b0;
        end else begin
          prev_q <= smp;
        end
      end

      assign hit           = sense_eval(code[2:0], smp, prev_q);
      assign level_evt[gi] = hit[1];
      assign edge_evt[gi]  = hit[0];
    end
  endgenerate

endmodule

// File: rtl/gis_pending.sv
module gis_pending #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] edge_evt,
  input  logic [NPINS-1:0] level_evt,
  input  logic [NPINS-1:0] det_en_q,
  input  logic [NPINS-1:0] clr_vec,
  output logic [NPINS-1:0] edge_hit,
  output logic [NPINS-1:0] level_hit,
  output logic [NPINS-1:0] pend_q
);

  logic [NPINS-1:0] pend_d;

  assign edge_hit  = edge_evt & det_en_q;
  assign level_hit = level_evt & det_en_q;

  // An edge beats a clear; a level loses to it and comes back next edge
  assign pend_d = edge_hit | ((pend_q | level_hit) & ~clr_vec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      pend_q <= pend_d;
    end
  end

endmodule

// File: rtl/gis_top.sv
module gis_top
  import gis_pkg::*;
#(
  parameter int NPINS       = 32,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int FPW        = DATA_W / FIELD_W,
  localparam int NSREG      = (NPINS + FPW - 1) / FPW,
  localparam int SENSE_W    = NSREG * DATA_W,
  localparam int NGROUP     = 2,
  localparam int HALF       = NPINS / NGROUP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pin_in,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_lo,
  output logic              irq_hi
);

  logic [NPINS-1:0]   det_en_q;
  logic [NPINS-1:0]   unmask_q;
  logic [SENSE_W-1:0] sense_flat;
  logic [NPINS-1:0]   clr_vec;
  logic               wr_unmask;
  logic               wr_mask;
  logic [NPINS-1:0]   edge_evt;
  logic [NPINS-1:0]   level_evt;
  logic [NPINS-1:0]   edge_hit;
  logic [NPINS-1:0]   level_hit;
  logic [NPINS-1:0]   pend_q;
  logic [NPINS-1:0]   status_w;
  logic [NGROUP-1:0]  irq_grp;

  assign status_w = pend_q & unmask_q;

  gis_regs #(
    .NPINS (NPINS),
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pend_q    (pend_q),
    .status_w  (status_w),
    .det_en_q  (det_en_q),
    .unmask_q  (unmask_q),
    .sense_flat(sense_flat),
    .clr_vec   (clr_vec),
    .wr_unmask (wr_unmask),
    .wr_mask   (wr_mask),
    .bus_rdata (bus_rdata)
  );

  gis_detect #(
    .NPINS      (NPINS),
    .SENSE_W    (SENSE_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_detect (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_in    (pin_in),
    .sense_flat(sense_flat),
    .edge_evt  (edge_evt),
    .level_evt (level_evt)
  );

  gis_pending #(
    .NPINS(NPINS)
  ) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .edge_evt (edge_evt),
    .level_evt(level_evt),
    .det_en_q (det_en_q),
    .clr_vec  (clr_vec),
    .edge_hit (edge_hit),
    .level_hit(level_hit),
    .pend_q   (pend_q)
  );

  genvar gg;
  generate
    for (gg = 0; gg < NGROUP; gg++) begin : g_irq
      assign irq_grp[gg] = |status_w[gg*HALF +: HALF];
    end
  endgenerate

  assign irq_lo = irq_grp[0];
  assign irq_hi = irq_grp[NGROUP-1];

endmodule

// File: rtl/gis_checker.sv
module gis_checker #(
  parameter int NPINS  = 32,
  parameter int DATA_W = 32,
  localparam int HALF  = NPINS / 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              wr_unmask,
  input logic              wr_mask,
  input logic [NPINS-1:0]  det_en_q,
  input logic [NPINS-1:0]  unmask_q,
  input logic [NPINS-1:0]  pend_q,
  input logic [NPINS-1:0]  edge_hit,
  input logic [NPINS-1:0]  clr_vec,
  input logic              irq_lo,
  input logic              irq_hi
);

  assert_det_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(det_en_q)) == '0));

  assert_unmask_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_unmask |=> (($past(bus_wdata[NPINS-1:0]) & ~unmask_q) == '0));

  assert_mask_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> (($past(bus_wdata[NPINS-1:0]) & unmask_q) == '0));

  assert_pend_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pend_q & ~clr_vec) & ~pend_q) == '0));

  assert_clear_takes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(clr_vec & ~edge_hit) & pend_q) == '0));

  assert_edge_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(edge_hit) & ~pend_q) == '0));

  assert_lo_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (unmask_q[HALF-1:0] == '0) |-> !irq_lo);

  assert_hi_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (unmask_q[NPINS-1:HALF] == '0) |-> !irq_hi);

endmodule

bind gis_top gis_checker #(.NPINS(NPINS), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_wdata(bus_wdata),
  .wr_unmask(wr_unmask),
  .wr_mask  (wr_mask),
  .det_en_q (det_en_q),
  .unmask_q (unmask_q),
  .pend_q   (pend_q),
  .edge_hit (edge_hit),
  .clr_vec  (clr_vec),
  .irq_lo   (irq_lo),
  .irq_hi   (irq_hi)
);

// File: tb/sim_gis_top.sv
module sim_gis_top;

  localparam logic [7:0] A_DETEN  = 8'h00;
  localparam logic [7:0] A_UNMASK = 8'h04;
  localparam logic [7:0] A_MASK   = 8'h08;
  localparam logic [7:0] A_RAW    = 8'h0C;
  localparam logic [7:0] A_STATUS = 8'h10;
  localparam logic [7:0] A_CLEAR  = 8'h14;
  localparam logic [7:0] A_SENSE  = 8'h20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pin_in = '0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_lo, irq_hi;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gis_top u0 (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_sel(bus_sel),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic chk_reg(input string req, input string what,
                         input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, what, v, exp);
  endtask

  task automatic chk_irq(input string req, input logic lo, input logic hi);
    chk(req, "irq_lo", {31'b0, irq_lo}, {31'b0, lo});
    chk(req, "irq_hi", {31'b0, irq_hi}, {31'b0, hi});
  endtask

  // One pin through one sense code on one sampling path
  task automatic run_mode(input int n, input int code, input bit direct);
    bit          idle;
    bit          lvl;
    logic [31:0] bit_n;
    logic [31:0] word;
    logic [7:0]  sa;
    bit_n = 32'(1) << n;
    idle  = (code == 1 || code == 3);
    lvl   = (code == 2 || code == 3);
    sa    = A_SENSE + 8'(4 * (n / 8));
    word  = {28'b0, direct, 3'(code)} << (4 * (n % 8));
    pin_in = '0;
    pin_in[n] = idle;
    wr(A_MASK, 32'hFFFF_FFFF);
    wr(A_DETEN, 32'h0);
    wr(sa, word);
    chk_reg("R2", "sense readback", sa, word);
    wr(A_DETEN, bit_n);
    wr(A_UNMASK, bit_n);
    tick(4);
    wr(A_CLEAR, 32'hFFFF_FFFF);
    chk_reg("R8", "raw after full clear", A_RAW, 32'h0);
    pin_in[n] = ~idle;
    if (code > 4) begin
      tick(4);
      chk_reg("R3", "unused code never latches", A_RAW, 32'h0);
      pin_in[n] = idle;
      tick(4);
      chk_reg("R3", "unused code after return", A_RAW, 32'h0);
      return;
    end
    if (direct) begin
      tick(1);
      chk_reg("R4", "direct path first edge", A_RAW, bit_n);
    end else begin
      tick(2);
      chk_reg("R4", "synchronized path second edge", A_RAW, 32'h0);
      tick(1);
      chk_reg("R4", "synchronized path third edge", A_RAW, bit_n);
    end
    chk_reg("R7", "status with pin enabled", A_STATUS, bit_n);
    chk_irq("R11", n < 16, n >= 16);
    wr(A_CLEAR, bit_n);
    chk_reg("R8", "raw right after clear", A_RAW, 32'h0);
    if (lvl) begin
      tick(1);
      chk_reg("R9", "level sets again", A_RAW, bit_n);
    end else begin
      tick(4);
      chk_reg("R3", "edge does not repeat", A_RAW, 32'h0);
    end
    pin_in[n] = idle;
    tick(4);
    chk_reg("R3", "after return to idle", A_RAW,
            (lvl || code == 4) ? bit_n : 32'h0);
  endtask

  initial begin
    logic [31:0] v;
    rst_n = 1'b0;
    tick(3);
    // R1: reset state
    foreach (v[k]) begin
      if (k < 16) chk_reg("R1", "register after reset", 8'(4 * k), 32'h0);
    end
    chk_irq("R1", 1'b0, 1'b0);
    rst_n = 1'b1;
    tick(2);
    chk_reg("R1", "raw after reset", A_RAW, 32'h0);
    chk_irq("R1", 1'b0, 1'b0);

    // R6: enable vector set/clear with zero bits untouched
    wr(A_UNMASK, 32'h0000_0011);
    wr(A_UNMASK, 32'h8000_0000);
    chk_reg("R6", "unmask accumulates", A_UNMASK, 32'h8000_0011);
    wr(A_MASK, 32'h0000_0010);
    chk_reg("R6", "mask clears only ones", A_UNMASK, 32'h8000_0001);
    wr(A_MASK, 32'hFFFF_FFFF);
    chk_reg("R6", "mask all", A_UNMASK, 32'h0);

    // R5: detection enable readback and gating (pin 3, direct rise)
    wr(A_SENSE, 32'h0000_8000);
    wr(A_DETEN, 32'h1234_5670);
    chk_reg("R5", "deten readback", A_DETEN, 32'h1234_5670);
    wr(A_DETEN, 32'h0);
    pin_in[3] = 1'b1;
    tick(3);
    chk_reg("R5", "disabled pin ignores edge", A_RAW, 32'h0);
    pin_in[3] = 1'b0;
    tick(2);

    // R8 zero bits: pins 2 and 5 pending, clear only pin 2
    wr(A_SENSE, 32'h0080_0800);
    wr(A_DETEN, 32'h0000_0024);
    pin_in[2] = 1'b1; pin_in[5] = 1'b1;
    tick(1);
    chk_reg("R7", "two pending", A_RAW, 32'h0000_0024);
    chk_reg("R7", "status all masked", A_STATUS, 32'h0);
    chk_irq("R11", 1'b0, 1'b0);
    wr(A_CLEAR, 32'h0000_0004);
    chk_reg("R8", "partial clear", A_RAW, 32'h0000_0020);
    tick(3);
    chk_reg("R7", "pending holds", A_RAW, 32'h0000_0020);

    // R10: edge and clear on the same edge (pin 2 rises again)
    pin_in[2] = 1'b0;
    tick(2);
    wr(A_CLEAR, 32'hFFFF_FFFF);
    chk_reg("R8", "cleared before race", A_RAW, 32'h0);
    pin_in[2] = 1'b1;
    wr(A_CLEAR, 32'h0000_0004);
    chk_reg("R10", "edge beats clear", A_RAW, 32'h0000_0004);
    pin_in = '0;
    wr(A_SENSE, 32'h0);
    wr(A_DETEN, 32'h0);
    tick(2);
    wr(A_CLEAR, 32'hFFFF_FFFF);

    // Sweep: every pin, every kind, both paths
    for (int n = 0; n < 32; n++) begin
      for (int c = 0; c < 5; c++) begin
        run_mode(n, c, 1'b1);
        run_mode(n, c, 1'b0);
      end
    end
    // Unused codes on a few pins
    for (int c = 5; c < 8; c++) begin
      run_mode(c, c, 1'b1);
      run_mode(20 + c, c, 1'b0);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule